// File: doc/BRIEF.md
# Side-Clock Serial Memory Streamer

This block streams the lower 128 bytes of a 256-byte memory onto an open-drain data line whose pull-up sits outside the block. A slow side clock, separate from the bus clock, sets the pace. A fast system clock samples that side clock, and each rising edge moves the stream forward by one bit. After reset the block counts nine side-clock rising edges with the line released. From the tenth edge onward it sends bytes without a break. Each byte goes out as eight data bits, most significant first, and is followed by a released null slot. Addresses count up from zero and wrap back to zero after the last byte of the 128-byte window.

A mode controller drives the enable. While the enable is low the line is released and all progress stops. A restart pulse sends the stream back to address zero without repeating the start-up count. The data path has no valid/ready handshake. The side clock alone sets the pace, so there is no back-pressure at either edge. The read port shows an address that is held stable for at least one whole side-clock period before its byte is taken. The memory must return that byte on the read data input before the next side-clock rising edge.

Top module: `side_stream_top`

## Requirements
- R1: Immediately after reset, the drive output is 0 (line released) and the read address is 0.
- R2: The first nine side-clock rising edges after reset leave the line released. The tenth rising edge starts the bit for bit 7 of the byte at address 0.
- R3: The driven bit changes only in response to a side-clock rising edge, a restart or an enable change. It shows a new bit within three system-clock cycles of a side-clock rise, provided the side clock holds each level for at least three system clocks.
- R4: Each byte is sent as eight bits, bit 7 first and bit 0 last. A 0 bit sets the drive output to 1 (pull low). A 1 bit sets it to 0 (release).
- R5: A ninth slot follows every byte, and in that slot the drive output is 0.
- R6: The read address begins at 0 and steps up by exactly one as each byte's null slot begins. Its bit 7 is always 0.
- R7: The null slot of address 127 is followed by the byte at address 0, with no extra slot between them.
- R8: A one-cycle restart pulse sets the address to 0 and releases the line. The next side-clock rise then starts bit 7 of address 0. A restart that arrives during the start-up count neither shortens nor lengthens that count.
- R9: While the enable is low the line is released and side-clock edges are ignored. Once the enable is high again, the stream carries on from the exact bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the side clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| side_clk_i | input | 1 | Side-clock level, asynchronous to clk |
| enable_i | input | 1 | Streamer enable from the mode controller |
| restart_i | input | 1 | One-cycle restart request |
| mem_rd_addr_o | output | 8 | Read address into the memory array |
| mem_rd_data_i | input | 8 | Byte read from the memory array |
| sda_drive_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Most internal faults appear on the drive output within three system clocks of the next side-clock rise. A start-up counter that is off by one shifts every later bit by one slot. This is caught at the tenth edge, where bit 7 of byte 0 should first appear. A wrong bit index or null-slot decision corrupts a byte, or drives the line during a slot that must be released, within the nine edges of that byte. Address faults show directly on the read port at the start of the affected null slot. Wrap faults show at the 128th byte boundary. An enable that fails to freeze the block, or a restart that resets the start-up count, moves the bit stream out of step with the reference model on the very next edge.

// File: rtl/side_stream_pkg.sv
package side_stream_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_DATA = 2'd1,
    PH_GAP  = 2'd2
  } stream_phase_e;
endpackage

// File: rtl/side_edge_sync.sv
module side_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic side_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= side_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], side_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stream_sequencer.sv
module stream_sequencer
  import side_stream_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int SYNC_EDGES = 9,
  parameter int BITS       = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            step_i,
  input  logic                            restart_i,
  output stream_phase_e                   phase_o,
  output logic [$clog2(SYNC_EDGES+1)-1:0] sync_cnt_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic                            load_o,
  output logic                            shift_o
);
  localparam int CNT_W = $clog2(SYNC_EDGES+1);
  localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_EDGES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS-1);

  stream_phase_e     phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              adv;

  assign adv = step_i & ~restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else if (restart_i) begin
      addr_q <= '0;
      idx_q  <= '0;
      if (phase_q != PH_SYNC) phase_q <= PH_GAP;
    end else if (adv) begin
      unique case (phase_q)
        PH_SYNC: begin
          if (cnt_q == CNT_LAST) begin
            phase_q <= PH_DATA;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (idx_q == IDX_LAST) begin
            phase_q <= PH_GAP;
            addr_q  <= addr_q + 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_DATA;
          idx_q   <= '0;
        end
      endcase
    end
  end

  assign load_o  = adv & (((phase_q == PH_SYNC) & (cnt_q == CNT_LAST)) |
                          (phase_q == PH_GAP));
  assign shift_o = adv & (phase_q == PH_DATA) & (idx_q != IDX_LAST);

  assign phase_o    = phase_q;
  assign sync_cnt_o = cnt_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b1};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/side_stream_top.sv
module side_stream_top
  import side_stream_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MEM_ADDR_W  = 8,
  parameter int WINDOW      = 128,
  parameter int SYNC_EDGES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  side_clk_i,
  input  logic                  enable_i,
  input  logic                  restart_i,
  output logic [MEM_ADDR_W-1:0] mem_rd_addr_o,
  input  logic [DATA_W-1:0]     mem_rd_data_i,
  output logic                  sda_drive_o
);
  localparam int WIN_AW = $clog2(WINDOW);
  localparam int CNT_W  = $clog2(SYNC_EDGES+1);

  logic              rise_w;
  logic              step_w;
  stream_phase_e     phase_w;
  logic [CNT_W-1:0]  sync_cnt_w;
  logic [WIN_AW-1:0] win_addr_w;
  logic              load_w;
  logic              shift_w;
  logic              msb_w;

  side_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .side_i (side_clk_i),
    .rise_o (rise_w)
  );

  assign step_w = rise_w & enable_i;

  stream_sequencer #(
    .ADDR_W     (WIN_AW),
    .SYNC_EDGES (SYNC_EDGES),
    .BITS       (DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_w),
    .restart_i  (restart_i),
    .phase_o    (phase_w),
    .sync_cnt_o (sync_cnt_w),
    .addr_o     (win_addr_w),
    .load_o     (load_w),
    .shift_o    (shift_w)
  );

  byte_shifter #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .shift_i (shift_w),
    .data_i  (mem_rd_data_i),
    .msb_o   (msb_w)
  );

  generate
    if (MEM_ADDR_W > WIN_AW) begin : g_pad
      assign mem_rd_addr_o = {{(MEM_ADDR_W-WIN_AW){1'b0}}, win_addr_w};
    end else begin : g_flat
      assign mem_rd_addr_o = win_addr_w;
    end
  endgenerate

  assign sda_drive_o = enable_i & (phase_w == PH_DATA) & ~msb_w;
endmodule

// File: rtl/side_stream_chk.sv
module side_stream_chk
  import side_stream_pkg::*;
#(
  parameter int WIN_AW     = 7,
  parameter int CNT_W      = 4,
  parameter int SYNC_EDGES = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              restart_i,
  input logic              rise,
  input stream_phase_e     phase,
  input logic [CNT_W-1:0]  sync_cnt,
  input logic [WIN_AW-1:0] addr,
  input logic              drive
);
  assert_sync_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNC) |-> !drive);

  assert_sync_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cnt <= CNT_W'(SYNC_EDGES));

  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |-> !drive);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> ((addr == WIN_AW'($past(addr) + 1'b1)) ||
                        ((addr == '0) && $past(restart_i))));

  assert_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(drive) && $stable(enable_i)) |-> ($past(rise) || $past(restart_i)));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !restart_i) |=> ($stable(addr) && $stable(phase) && $stable(sync_cnt)));
endmodule

bind side_stream_top side_stream_chk #(
  .WIN_AW     (WIN_AW),
  .CNT_W      (CNT_W),
  .SYNC_EDGES (SYNC_EDGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .restart_i (restart_i),
  .rise      (rise_w),
  .phase     (phase_w),
  .sync_cnt  (sync_cnt_w),
  .addr      (win_addr_w),
  .drive     (sda_drive_o)
);

// File: tb/side_stream_top_tb.sv
module side_stream_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SIDE  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       side_clk = 1'b0;
  logic       en = 1'b1;
  logic       rs = 1'b0;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       drv;
  logic [7:0] mem [256];

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  bit         m_started;
  int         m_cnt;
  int         m_addr;
  int         m_pos;
  logic [7:0] m_byte;
  string      tag_force = "";

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = mem[rd_addr];

  side_stream_top u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .side_clk_i    (side_clk),
    .enable_i      (en),
    .restart_i     (rs),
    .mem_rd_addr_o (rd_addr),
    .mem_rd_data_i (rd_data),
    .sda_drive_o   (drv)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_drive();
    if (!en || !m_started || m_pos >= 8) return 0;
    return m_byte[7-m_pos] ? 0 : 1;
  endfunction

  function automatic string cur_tag(bit wrapped);
    if (tag_force != "") return tag_force;
    if (wrapped)         return "R7";
    if (!m_started)      return "R2";
    if (m_pos == 8)      return "R5";
    return "R4";
  endfunction

  task automatic model_edge(output bit wrapped);
    wrapped = 1'b0;
    if (!en) return;
    if (!m_started) begin
      if (m_cnt == 9) begin
        m_started = 1'b1; m_pos = 0; m_byte = mem[m_addr];
      end else m_cnt++;
    end else if (m_pos == 8) begin
      m_pos = 0; m_byte = mem[m_addr];
    end else if (m_pos == 7) begin
      m_pos = 8;
      wrapped = (m_addr == 127);
      m_addr = (m_addr + 1) % 128;
    end else m_pos++;
  endtask

  task automatic side_pulse();
    bit wr;
    @(negedge clk);
    check("R3", int'(drv), exp_drive());
    side_clk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_edge(wr);
    check(cur_tag(wr), int'(drv), exp_drive());
    check(wr ? "R7" : "R6", int'(rd_addr), m_addr);
    repeat (HALF_SIDE - 4) @(posedge clk);
    side_clk = 1'b0;
    repeat (HALF_SIDE) @(posedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk);
    rs = 1'b1;
    @(negedge clk);
    rs = 1'b0;
    m_addr = 0;
    if (m_started) m_pos = 8;
    @(negedge clk);
    check("R8", int'(drv), exp_drive());
    check("R8", int'(rd_addr), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; side_clk = 1'b0; en = 1'b1; rs = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_started = 1'b0; m_cnt = 0; m_addr = 0; m_pos = 0; m_byte = 8'hFF;
    @(negedge clk);
    check("R1", int'(drv), 0);
    check("R1", int'(rd_addr), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[0]   = 8'h5A;
    mem[1]   = 8'h00;
    mem[2]   = 8'hFF;
    mem[127] = 8'h96;

    do_reset();

    // R2: nine quiet edges, then bit 7 of address 0
    for (int i = 0; i < 9; i++) side_pulse();
    side_pulse();
    check("R2", int'(drv), 1);  // bit 7 of 0x5A is 0 -> pull low

    // R4/R5: rest of byte 0, null slot, and two more bytes
    for (int i = 0; i < 26; i++) side_pulse();

    // R7: run past the window end
    for (int i = 0; i < 126 * 9 + 4; i++) side_pulse();

    // R9: disabled edges are ignored
    @(negedge clk); en = 1'b0;
    tag_force = "R9";
    for (int i = 0; i < 5; i++) side_pulse();
    tag_force = "";
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 12; i++) side_pulse();

    // R8: restart mid-byte, then bit 7 of address 0 on the next edge
    for (int i = 0; i < 3; i++) side_pulse();
    do_restart();
    tag_force = "R8";
    side_pulse();
    tag_force = "";
    for (int i = 0; i < 10; i++) side_pulse();

    // random mix of restarts and enable toggles
    for (int i = 0; i < 500; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) do_restart();
      else if (r == 1) begin
        @(negedge clk); en = ~en;
      end
      side_pulse();
    end

    // R8: restart during start-up keeps the nine-edge count
    do_reset();
    for (int i = 0; i < 4; i++) side_pulse();
    do_restart();
    tag_force = "R8";
    for (int i = 0; i < 6; i++) side_pulse();
    check("R8", int'(drv), 1);
    tag_force = "";
    for (int i = 0; i < 20; i++) side_pulse();

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule